// File: doc/BRIEF.md
# Debug Command Register and Execute Sequencer

This block sits behind a JTAG TAP and turns a 10-bit serial debug command into register accesses and CPU execute requests. A command is shifted in on TDI, least significant bit first, while `cmd_sel` is high. Its parallel copy changes only when Update-DR arrives. The command carries four fields: a direction bit, a GO bit, an EX bit and a 7-bit register select. The data scans that follow, taken with `cmd_sel` low, move 32-bit words. On a read, the selected register is captured in Capture-DR and shifted out on TDO. On a write, the shifted word is handed to the register file when Update-DR arrives.

GO asks the CPU to leave debug mode and run the instruction it holds. GO is honoured only while the CPU reports debug mode, and only for two register selects. With the CPU scan-chain select (7'h10), the request fires at Update-DR of the following data scan. With the "no register" select (7'h7F), it fires at Update-DR of the command itself. EX chooses between two outcomes. With EX clear, the CPU runs one instruction and comes back to debug mode. With EX set, the CPU resumes normal running, unless another debug request is pending. On a resume, interrupts stay blocked until the CPU reports that the first instruction has started.

Top module: `dbg_cmd_seq`

## Requirements
- R1: `por_n` low or `trst_n` low sets the command to 10'b1000000010, so `reg_sel` reads 7'h40 with write direction and GO set. The command holds that value on every clock in which `tlr` is high. A data update made with this value produces a write strobe.
- R2: The command is shifted LSB first while `cmd_sel` and `shift_dr` are high. Its bits are: bit 0 direction (0 write, 1 read), bit 1 GO, bit 2 EX, bits 9:3 register select. `reg_sel` and the other decoded fields change only on a clock where `upd_dr` and `cmd_sel` are both high.
- R3: A data update (`upd_dr` high, `cmd_sel` low) with direction 0 and a select other than 7'h7F raises `wr_stb` for exactly the next cycle. `wr_data` then holds the 32 bits shifted in, LSB first.
- R4: A data capture with direction 1 and a select other than 7'h7F drives `rd_stb` high in the Capture-DR cycle and loads `rd_data`. The following 32 shift clocks then present that word on `tdo`, LSB first. With any other command, the captured word is zero.
- R5: GO has no effect while `cpu_dbg` is low.
- R6: GO raises `exec_req` only for select 7'h7F, at its command update, or for select 7'h10, at the next data update. No other select produces `exec_req`.
- R7: `exec_req` is a single-cycle pulse. It starts in the cycle after the Update-DR clock and is never high during capture or shift.
- R8: With each request, `exec_ex` takes the EX bit. `exec_resume` is high only when EX is 1 and `other_dbg_req` was low at Update-DR.
- R9: A request with EX = 1 sets `irq_blk`; a request with EX = 0 leaves it clear. A `cpu_done` pulse clears it.
- R10: `left_dbg` goes high together with `exec_req` and stays high until a `cpu_done` pulse clears it.
- R11: Select 7'h7F never produces `wr_stb` or `rd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| trst_n | input | 1 | TAP reset, active low, asynchronous |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| cap_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| upd_dr | input | 1 | TAP is in Update-DR |
| cmd_sel | input | 1 | Scan targets the command register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| cpu_dbg | input | 1 | CPU is in debug mode |
| cpu_done | input | 1 | CPU re-entered debug mode or started its first instruction |
| other_dbg_req | input | 1 | Another debug request is pending |
| exec_req | output | 1 | One-cycle request to run the held instruction |
| exec_ex | output | 1 | EX bit of the last request |
| exec_resume | output | 1 | Last request resumes normal running |
| left_dbg | output | 1 | Debug mode left, not yet acknowledged |
| irq_blk | output | 1 | Interrupts blocked after an exit |
| reg_sel | output | 7 | Current register select |
| rd_stb | output | 1 | Register read strobe |
| rd_data | input | 32 | Read data from the selected register |
| wr_stb | output | 1 | Register write strobe |
| wr_data | output | 32 | Write data for the selected register |

## Verification
The main sweep runs a command and a data scan for every register select. It crosses GO on and off with `cpu_dbg` high and low, and lets the select bits set the direction and EX. This sweep separates the two GO-honouring selects from all the others. It also separates the select whose request fires at command update (7'h7F) from the one that fires at data update (7'h10). Every read is checked against a word derived from the select, which shows the shift order and catches any read from the wrong register. Directed runs cover the three reset paths and a resume attempted while another debug request is pending, which must block the resume.

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq #(
  parameter int         DW      = 32,
  parameter logic [6:0] RS_SCAN = 7'h10,
  parameter logic [6:0] RS_NONE = 7'h7F
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          trst_n,
  input  logic          tlr,
  input  logic          cap_dr,
  input  logic          shift_dr,
  input  logic          upd_dr,
  input  logic          cmd_sel,
  input  logic          tdi,
  output logic          tdo,
  input  logic          cpu_dbg,
  input  logic          cpu_done,
  input  logic          other_dbg_req,
  output logic          exec_req,
  output logic          exec_ex,
  output logic          exec_resume,
  output logic          left_dbg,
  output logic          irq_blk,
  output logic [6:0]    reg_sel,
  output logic          rd_stb,
  input  logic [DW-1:0] rd_data,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);
  localparam int            CW      = 10;
  localparam logic [CW-1:0] CMD_RST = 10'b1000000010;

  logic          rst_n;
  logic [CW-1:0] cmd_sr, cmd;
  logic [DW-1:0] dat_sr;
  logic          trig_cmd, trig_dat, trig, trig_ex;

  assign rst_n   = por_n & trst_n;
  assign reg_sel = cmd[9:3];
  assign tdo     = cmd_sel ? cmd_sr[0] : dat_sr[0];
  assign rd_stb  = cap_dr & ~cmd_sel & cmd[0] & (cmd[9:3] != RS_NONE);

  // GO for the no-register select acts on the command's own update
  assign trig_cmd = upd_dr & cmd_sel & ~tlr & cpu_dbg & cmd_sr[1] & (cmd_sr[9:3] == RS_NONE);
  assign trig_dat = upd_dr & ~cmd_sel & ~tlr & cpu_dbg & cmd[1] & (cmd[9:3] == RS_SCAN);
  assign trig     = trig_cmd | trig_dat;
  assign trig_ex  = trig_cmd ? cmd_sr[2] : cmd[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_sr      <= CMD_RST;
      cmd         <= CMD_RST;
      dat_sr      <= '0;
      wr_stb      <= 1'b0;
      wr_data     <= '0;
      exec_req    <= 1'b0;
      exec_ex     <= 1'b0;
      exec_resume <= 1'b0;
      left_dbg    <= 1'b0;
      irq_blk     <= 1'b0;
    end else begin
      if (cmd_sel && shift_dr) cmd_sr <= {tdi, cmd_sr[CW-1:1]};

      if (tlr)                     cmd <= CMD_RST;
      else if (cmd_sel && upd_dr)  cmd <= cmd_sr;

      if (!cmd_sel) begin
        if (cap_dr)        dat_sr <= rd_stb ? rd_data : '0;
        else if (shift_dr) dat_sr <= {tdi, dat_sr[DW-1:1]};
      end

      wr_stb <= upd_dr & ~cmd_sel & ~tlr & ~cmd[0] & (cmd[9:3] != RS_NONE);
      if (upd_dr && !cmd_sel && !tlr && !cmd[0] && cmd[9:3] != RS_NONE) wr_data <= dat_sr;

      exec_req <= trig;
      if (trig) begin
        exec_ex     <= trig_ex;
        exec_resume <= trig_ex & ~other_dbg_req;
      end

      if (trig)          left_dbg <= 1'b1;
      else if (cpu_done) left_dbg <= 1'b0;

      if (trig)          irq_blk <= trig_ex;
      else if (cpu_done) irq_blk <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       trst_n,
  input logic       tlr,
  input logic       cap_dr,
  input logic       shift_dr,
  input logic       upd_dr,
  input logic       cmd_sel,
  input logic       cpu_dbg,
  input logic       exec_req,
  input logic       exec_ex,
  input logic       left_dbg,
  input logic       irq_blk,
  input logic [6:0] reg_sel,
  input logic       wr_stb
);
  a_r7_exec_single: assert property (@(posedge clk) disable iff (!por_n || !trst_n)
    exec_req |=> !exec_req);
  a_r5_exec_needs_dbg: assert property (@(posedge clk) disable iff (!por_n || !trst_n)
    exec_req |-> $past(cpu_dbg) && $past(upd_dr));
  a_r7_no_exec_in_shift: assert property (@(posedge clk) disable iff (!por_n || !trst_n)
    exec_req |-> !$past(shift_dr) && !$past(cap_dr));
  a_r3_wr_after_update: assert property (@(posedge clk) disable iff (!por_n || !trst_n)
    wr_stb |-> $past(upd_dr) && !$past(cmd_sel));
  a_r10_left_with_exec: assert property (@(posedge clk) disable iff (!por_n || !trst_n)
    $rose(left_dbg) |-> exec_req);
  a_r9_irq_needs_ex: assert property (@(posedge clk) disable iff (!por_n || !trst_n)
    irq_blk |-> exec_ex);
  a_r1_tlr_holds_reset: assert property (@(posedge clk) disable iff (!por_n || !trst_n)
    tlr |=> reg_sel == 7'h40);
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk u_chk (
  .clk, .por_n, .trst_n, .tlr, .cap_dr, .shift_dr, .upd_dr, .cmd_sel, .cpu_dbg,
  .exec_req, .exec_ex, .left_dbg, .irq_blk, .reg_sel, .wr_stb
);

// File: tb/dbg_cmd_seq_test.sv
`timescale 1ns/1ps
module dbg_cmd_seq_test;
  logic clk = 0, por_n = 0, trst_n = 1, tlr = 0;
  logic cap_dr = 0, shift_dr = 0, upd_dr = 0, cmd_sel = 0, tdi = 0, tdo;
  logic cpu_dbg = 0, cpu_done = 0, other_dbg_req = 0;
  logic exec_req, exec_ex, exec_resume, left_dbg, irq_blk, rd_stb, wr_stb;
  logic [6:0]  reg_sel;
  logic [31:0] rd_data, wr_data;
  int checks = 0, errors = 0;
  logic s_exec, s_exec2, s_wr, s_wr2, s_res, s_irq, s_left, s_ex, s_rd, early;
  logic [31:0] s_wd, dout;
  logic [6:0]  sel_pre;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] model_rd(input logic [6:0] rs);
    return ({rs, 25'h0} ^ (32'h01010101 * {25'h0, rs})) ^ 32'h5A3C96E1;
  endfunction
  assign rd_data = model_rd(reg_sel);

  dbg_cmd_seq uut (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input logic sel, input logic [31:0] din, input int n);
    dout = '0; early = 0;
    cmd_sel = sel; cap_dr = 1; #1 s_rd = rd_stb;
    if (exec_req) early = 1;
    @(posedge clk); @(negedge clk); cap_dr = 0; shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo; tdi = din[i];
      if (exec_req) early = 1;
      @(posedge clk); @(negedge clk);
    end
    shift_dr = 0; sel_pre = reg_sel; upd_dr = 1;
    @(posedge clk); @(negedge clk); upd_dr = 0;
    s_exec = exec_req; s_wr = wr_stb; s_wd = wr_data; s_res = exec_resume;
    s_irq = irq_blk; s_left = left_dbg; s_ex = exec_ex;
    @(posedge clk); @(negedge clk);
    s_exec2 = exec_req; s_wr2 = wr_stb;
  endtask

  task automatic done_pulse();
    cpu_done = 1; @(posedge clk); @(negedge clk); cpu_done = 0;
    chk(!left_dbg, "R10 left cleared", {31'h0, left_dbg}, 0);
    chk(!irq_blk, "R9 irq cleared", {31'h0, irq_blk}, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; @(negedge clk);
    chk(reg_sel == 7'h40, "R1 reset select", {25'h0, reg_sel}, 32'h40);
    chk(!exec_req && !wr_stb && !left_dbg, "R1 reset outputs", {29'h0, exec_req, wr_stb, left_dbg}, 0);
    scan(0, 32'hCAFE0001, 32);
    chk(s_wr && s_wd == 32'hCAFE0001, "R1 reset cmd writes", s_wd, 32'hCAFE0001);

    for (int rs = 0; rs < 128; rs++)
      for (int g = 0; g < 2; g++)
        for (int c = 0; c < 2; c++) begin
          logic rw, ex, ex_cmd, ex_dat, wr_e, rd_e;
          logic [31:0] din;
          logic [6:0] prev;
          rw = rs[0]; ex = rs[1];
          cpu_dbg = c[0]; prev = reg_sel;
          scan(1, {22'h0, rs[6:0], ex, g[0], rw}, 10);
          chk(sel_pre == prev, "R2 select stable before update", {25'h0, sel_pre}, {25'h0, prev});
          chk(reg_sel == rs[6:0], "R2 select loaded", {25'h0, reg_sel}, rs);
          ex_cmd = g[0] && c[0] && rs == 7'h7F;
          chk(s_exec == ex_cmd && !early, "R6 exec at command update", {31'h0, s_exec}, {31'h0, ex_cmd});
          if (ex_cmd) begin
            chk(!s_exec2, "R7 single pulse", {31'h0, s_exec2}, 0);
            chk(s_ex == ex && s_res == ex, "R8 resume follows EX", {30'h0, s_ex, s_res}, {30'h0, ex, ex});
            chk(s_irq == ex && s_left, "R9 R10 flags set", {30'h0, s_irq, s_left}, {30'h0, ex, 1'b1});
            done_pulse();
          end
          din = 32'h13579BDF ^ (32'h00010001 * rs);
          scan(0, din, 32);
          rd_e = rw && rs != 7'h7F;
          wr_e = !rw && rs != 7'h7F;
          chk(s_rd == rd_e, "R4 R11 read strobe", {31'h0, s_rd}, {31'h0, rd_e});
          chk(dout == (rd_e ? model_rd(rs[6:0]) : 32'h0), "R4 read data on tdo", dout,
              rd_e ? model_rd(rs[6:0]) : 32'h0);
          chk(s_wr == wr_e && !s_wr2, "R3 R11 write strobe", {30'h0, s_wr, s_wr2}, {30'h0, wr_e, 1'b0});
          if (wr_e) chk(s_wd == din, "R3 write data", s_wd, din);
          ex_dat = g[0] && c[0] && rs == 7'h10;
          chk(s_exec == ex_dat && !early, "R5 R6 R7 exec at data update", {31'h0, s_exec}, {31'h0, ex_dat});
          if (ex_dat) begin
            chk(!s_exec2, "R7 single pulse", {31'h0, s_exec2}, 0);
            chk(s_ex == ex && s_res == ex, "R8 resume follows EX", {30'h0, s_ex, s_res}, {30'h0, ex, ex});
            chk(s_irq == ex && s_left, "R9 R10 flags set", {30'h0, s_irq, s_left}, {30'h0, ex, 1'b1});
            done_pulse();
          end
        end

    cpu_dbg = 1; other_dbg_req = 1;
    scan(1, {22'h0, 7'h7F, 1'b1, 1'b1, 1'b1}, 10);
    chk(s_exec && !s_res && s_ex, "R8 other request blocks resume", {29'h0, s_exec, s_res, s_ex}, 32'h5);
    chk(s_left && s_irq, "R9 R10 exit flags", {30'h0, s_left, s_irq}, 32'h3);
    cpu_dbg = 0; other_dbg_req = 0;
    chk(left_dbg, "R10 flag holds until done", {31'h0, left_dbg}, 1);
    done_pulse();

    scan(1, {22'h0, 7'h22, 3'b001}, 10);
    tlr = 1; @(posedge clk); @(negedge clk); tlr = 0;
    chk(reg_sel == 7'h40, "R1 tlr reset", {25'h0, reg_sel}, 32'h40);
    scan(1, {22'h0, 7'h33, 3'b001}, 10);
    trst_n = 0; #1;
    chk(reg_sel == 7'h40, "R1 trst reset", {25'h0, reg_sel}, 32'h40);
    @(negedge clk); trst_n = 1; @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule